// File: doc/BRIEF.md
# Slot-Gated HDLC Frame Transmitter

This block serialises HDLC frames onto a shared time-division line. Frame bytes are written into a small internal queue. Each frame goes out as an opening flag, its bytes with zero-bit insertion, and a closing flag, one bit per bit strobe. Bits are sent only while the slot-enable input marks the block's own transmit slot. Between frames the block drives idle ones in its slot. Outside the slot its output is released, with the output enable low.

A shared collision-data input gates sending. It is looked at only during the block's own slot bits. While it is low the block sends nothing and starts no frame. If it drops during a frame, the frame is abandoned at once and the output is released. Because the queue keeps every byte of a frame until that frame's closing flag has gone out, an abandoned frame is normally replayed from its first byte when the line comes back.

The queue can run full while a long frame is in flight. A new write then evicts the oldest byte that has already been sent, so the start of the frame is lost. If the frame is then abandoned, or the queue runs dry in mid-frame, the block raises a sticky failure interrupt and throws away the rest of that frame.

Top module: `gated_hdlc_tx`

## Requirements
- R1: After reset, the output enable `txd_oe` is 0, `xdu_irq` is 0 and `wr_full` is 0.
- R2: A bit strobe outside the slot (`bit_en`=1, `slot_en`=0) drives `txd_oe` low from the next clock. The value of `cdr_in` on such a strobe neither aborts nor changes the frame being sent.
- R3: On a slot bit with `cdr_in` high and no byte queued, the block drives `txd`=1 with `txd_oe`=1 from the next clock (idle fill).
- R4: On a slot bit with `cdr_in` low and a frame queued, `txd_oe` is 0 from the next clock and no frame bit is consumed. The first slot bit with `cdr_in` high then sends the first bit of the opening flag.
- R5: A frame is sent as the flag 0x7E, then each byte least significant bit first, then the flag 0x7E. Each bit appears on `txd` one clock after its slot bit strobe. A frame's last byte is the one written with `wr_last`=1.
- R6: Within the frame body, a 0 is inserted after every five consecutive 1s, including just before the closing flag. Flags are never stuffed.
- R7: On a slot bit with `cdr_in` low while a frame is being sent, `txd_oe` is 0 from the next clock and the frame is abandoned.
- R8: If the abandoned frame's first byte is still queued, the next slot bit with `cdr_in` high resends the whole frame from its opening flag, and `xdu_irq` stays 0.
- R9: Bytes of a frame stay queued until its closing flag is sent. When the queue holds `FIFO_DEPTH` bytes, `wr_full` is 1 only if none of them has been sent yet. Otherwise a write is accepted and evicts the oldest sent byte.
- R10: If a frame whose start has been evicted is abandoned, `xdu_irq` is 1 from the next clock. The frame's remaining bytes up to its last byte are discarded, and the next frame is sent normally.
- R11: `xdu_irq` stays set until `xdu_clr` is 1 for a clock. A new failure in that same clock keeps it set.
- R12: If no byte is queued when a frame body needs one, `xdu_irq` is set and the frame's remaining bytes up to its last byte are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit strobe, one line bit per strobe |
| slot_en | input | 1 | High during the block's transmit slot |
| cdr_in | input | 1 | Shared collision-data gate, low inhibits sending |
| wr_valid | input | 1 | Write one byte into the queue |
| wr_data | input | 8 | Byte to queue |
| wr_last | input | 1 | Marks the last byte of a frame |
| wr_full | output | 1 | Queue full with nothing evictable; the write is dropped |
| xdu_clr | input | 1 | Clears the failure interrupt |
| txd | output | 1 | Serial line data |
| txd_oe | output | 1 | Line driver enable, low means high impedance |
| xdu_irq | output | 1 | Sticky transmit-failure interrupt |

## Verification
Zero insertion and the closing flag can compete for the same slot bit. This happens when a frame's last byte ends in five 1s: the stuffed 0 must go out first, and the flag must follow it unstuffed. The bench provokes this with a final byte of 0xF8. It rebuilds the expected bit stream on its own from the flag and stuffing rules and compares it bit by bit with the captured line. A second collision, between abandonment and an eviction that has just removed the frame's start, is provoked by filling the queue, sending two bytes, writing two more and then pulling the gate low. It is judged on the interrupt and on the clean transmission of the frame that follows.

// File: rtl/gtx_pkg.sv
package gtx_pkg;
  localparam int BYTE_W    = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);
  localparam int RUN_W     = 3;
  localparam logic [BYTE_W-1:0]  FLAG_PAT  = 8'h7E;
  localparam logic [RUN_W-1:0]   STUFF_RUN = 3'd5;
  localparam logic [BIT_IDX_W-1:0] LAST_IDX = BIT_IDX_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    S_IDLE,
    S_OPEN,
    S_DATA,
    S_CLOSE,
    S_DISCARD
  } ser_state_e;
endpackage

// File: rtl/gtx_frame_fifo.sv
module gtx_frame_fifo
  import gtx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              push_last,
  input  logic              pop,
  input  logic              commit,
  input  logic              rewind,
  input  logic              drop,
  output logic [BYTE_W-1:0] head_data,
  output logic              head_last,
  output logic              head_avail,
  output logic              wr_block,
  output logic              start_lost
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] CAP = PW'(DEPTH);

  logic [BYTE_W-1:0] data_mem [DEPTH];
  logic              last_mem [DEPTH];

  logic [PW-1:0] wr_q, rd_q, base_q;
  logic [PW-1:0] wr_d, rd_d, base_d;
  logic          lost_q, lost_d;
  logic [PW-1:0] occ;
  logic          at_cap, sent_held, accept, evict;

  always_comb begin
    occ       = wr_q - base_q;
    at_cap    = (occ == CAP);
    sent_held = (rd_q != base_q);
    wr_block  = at_cap && !(sent_held && !rewind);
    accept    = push && !wr_block;
    evict     = accept && at_cap && !commit && !drop;

    wr_d   = accept ? wr_q + 1'b1 : wr_q;
    if (rewind)            rd_d = base_q;
    else if (pop || drop)  rd_d = rd_q + 1'b1;
    else                   rd_d = rd_q;

    if (drop)        base_d = rd_q + 1'b1;
    else if (commit) base_d = rd_q;
    else if (evict)  base_d = base_q + 1'b1;
    else             base_d = base_q;

    if (drop || commit) lost_d = 1'b0;
    else if (evict)     lost_d = 1'b1;
    else                lost_d = lost_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      rd_q   <= '0;
      base_q <= '0;
      lost_q <= 1'b0;
    end else begin
      wr_q   <= wr_d;
      rd_q   <= rd_d;
      base_q <= base_d;
      lost_q <= lost_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      data_mem[wr_q[AW-1:0]] <= push_data;
      last_mem[wr_q[AW-1:0]] <= push_last;
    end
  end

  assign head_data  = data_mem[rd_q[AW-1:0]];
  assign head_last  = last_mem[rd_q[AW-1:0]];
  assign head_avail = (rd_q != wr_q);
  assign start_lost = lost_q;

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_q - base_q) <= CAP);

  // R9
  read_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_q - base_q) <= (wr_q - base_q));
endmodule

// File: rtl/gtx_frame_serializer.sv
module gtx_frame_serializer
  import gtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              abort,
  input  logic              head_avail,
  input  logic [BYTE_W-1:0] head_data,
  input  logic              head_last,
  input  logic              start_lost,
  output logic              line_bit,
  output logic              pop,
  output logic              commit,
  output logic              rewind,
  output logic              drop,
  output logic              fail_set
);
  ser_state_e           state_q, state_d;
  logic [BIT_IDX_W-1:0] cnt_q, cnt_d;
  logic [RUN_W-1:0]     ones_q, ones_d;
  logic                 dbit;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    ones_d   = ones_q;
    line_bit = 1'b1;
    pop      = 1'b0;
    commit   = 1'b0;
    rewind   = 1'b0;
    drop     = 1'b0;
    fail_set = 1'b0;
    dbit     = head_data[cnt_q];

    if (abort && (state_q == S_OPEN || state_q == S_DATA || state_q == S_CLOSE)) begin
      cnt_d  = '0;
      ones_d = '0;
      if (start_lost) begin
        fail_set = 1'b1;
        if (state_q == S_CLOSE) begin
          commit  = 1'b1;
          state_d = S_IDLE;
        end else begin
          state_d = S_DISCARD;
        end
      end else begin
        rewind  = 1'b1;
        state_d = S_IDLE;
      end
    end else begin
      case (state_q)
        S_IDLE: begin
          if (step && head_avail) begin
            line_bit = FLAG_PAT[0];
            cnt_d    = BIT_IDX_W'(1);
            state_d  = S_OPEN;
          end
        end
        S_OPEN: begin
          if (step) begin
            line_bit = FLAG_PAT[cnt_q];
            cnt_d    = cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) begin
              state_d = S_DATA;
              ones_d  = '0;
            end
          end
        end
        S_DATA: begin
          if (step) begin
            if (ones_q == STUFF_RUN) begin
              line_bit = 1'b0;
              ones_d   = '0;
            end else if (!head_avail) begin
              fail_set = 1'b1;
              cnt_d    = '0;
              ones_d   = '0;
              state_d  = S_DISCARD;
            end else begin
              line_bit = dbit;
              ones_d   = dbit ? ones_q + 1'b1 : '0;
              cnt_d    = cnt_q + 1'b1;
              if (cnt_q == LAST_IDX) begin
                pop = 1'b1;
                if (head_last) state_d = S_CLOSE;
              end
            end
          end
        end
        S_CLOSE: begin
          if (step) begin
            if (ones_q == STUFF_RUN) begin
              line_bit = 1'b0;
              ones_d   = '0;
            end else begin
              line_bit = FLAG_PAT[cnt_q];
              cnt_d    = cnt_q + 1'b1;
              if (cnt_q == LAST_IDX) begin
                commit  = 1'b1;
                state_d = S_IDLE;
              end
            end
          end
        end
        S_DISCARD: begin
          if (head_avail) begin
            drop = 1'b1;
            if (head_last) state_d = S_IDLE;
          end
        end
        default: state_d = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      ones_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ones_q  <= ones_d;
    end
  end

  // R4
  gate_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !step) |=> (state_q == S_IDLE));

  // R6
  stuff_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ones_q <= STUFF_RUN));

  // R8
  rewind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (state_q == S_IDLE));
endmodule

// File: rtl/gtx_line_gate.sv
module gtx_line_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic slot_en,
  input  logic cdr_in,
  input  logic line_bit,
  output logic step,
  output logic abort,
  output logic txd,
  output logic txd_oe
);
  logic slot_bit;
  logic txd_d, oe_d;

  always_comb begin
    slot_bit = bit_en && slot_en;
    step     = slot_bit && cdr_in;
    abort    = slot_bit && !cdr_in;
    oe_d     = txd_oe;
    txd_d    = txd;
    if (bit_en) begin
      oe_d  = step;
      txd_d = step ? line_bit : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd    <= 1'b1;
      txd_oe <= 1'b0;
    end else begin
      txd    <= txd_d;
      txd_oe <= oe_d;
    end
  end

  // R2
  out_of_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !slot_en) |=> !txd_oe);

  // R7
  abort_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && slot_en && !cdr_in) |=> !txd_oe);

  // R3
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(txd_oe));
endmodule

// File: rtl/gated_hdlc_tx.sv
module gated_hdlc_tx
  import gtx_pkg::*;
#(
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              slot_en,
  input  logic              cdr_in,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              wr_last,
  output logic              wr_full,
  input  logic              xdu_clr,
  output logic              txd,
  output logic              txd_oe,
  output logic              xdu_irq
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              step, abort, line_bit;
  logic              pop, commit, rewind, drop, fail_set;
  logic [BYTE_W-1:0] head_data;
  logic              head_last, head_avail, start_lost;
  logic              xdu_d;

  gtx_frame_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .push       (wr_valid),
    .push_data  (wr_data),
    .push_last  (wr_last),
    .pop        (pop),
    .commit     (commit),
    .rewind     (rewind),
    .drop       (drop),
    .head_data  (head_data),
    .head_last  (head_last),
    .head_avail (head_avail),
    .wr_block   (wr_full),
    .start_lost (start_lost)
  );

  gtx_frame_serializer u_ser (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .step       (step),
    .abort      (abort),
    .head_avail (head_avail),
    .head_data  (head_data),
    .head_last  (head_last),
    .start_lost (start_lost),
    .line_bit   (line_bit),
    .pop        (pop),
    .commit     (commit),
    .rewind     (rewind),
    .drop       (drop),
    .fail_set   (fail_set)
  );

  gtx_line_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .bit_en   (bit_en),
    .slot_en  (slot_en),
    .cdr_in   (cdr_in),
    .line_bit (line_bit),
    .step     (step),
    .abort    (abort),
    .txd      (txd),
    .txd_oe   (txd_oe)
  );

  always_comb begin
    if (fail_set)     xdu_d = 1'b1;
    else if (xdu_clr) xdu_d = 1'b0;
    else              xdu_d = xdu_irq;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) xdu_irq <= 1'b0;
    else            xdu_irq <= xdu_d;
  end

  // R11
  xdu_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (xdu_irq && !xdu_clr) |=> xdu_irq);

  // R10
  xdu_raise_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    fail_set |=> xdu_irq);
endmodule

// File: tb/gated_hdlc_tx_bench.sv
module gated_hdlc_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en, slot_en, cdr_in;
  logic       wr_valid, wr_last, xdu_clr;
  logic [7:0] wr_data;
  logic       wr_full, txd, txd_oe, xdu_irq;

  int n_chk  = 0;
  int n_fail = 0;

  logic cap [0:1023];
  int   capn;
  logic expv [0:1023];
  int   expn;
  logic [7:0] fb [0:15];
  int   fn;

  always #4 clk = ~clk;

  gated_hdlc_tx #(.FIFO_DEPTH(8)) u_gated_hdlc_tx (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .slot_en(slot_en), .cdr_in(cdr_in),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_full(wr_full),
    .xdu_clr(xdu_clr), .txd(txd), .txd_oe(txd_oe), .xdu_irq(xdu_irq)
  );

  task automatic chk(input string req, input logic act, input logic expct, input string what);
    n_chk++;
    if (act !== expct) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, expct);
    end
  endtask

  task automatic line_step(input logic be, input logic sl, input logic cd);
    bit_en = be; slot_en = sl; cdr_in = cd;
    @(posedge clk); #2;
    if (txd_oe === 1'b1 && capn < 1024) begin
      cap[capn] = txd;
      capn++;
    end
    bit_en = 1'b0; slot_en = 1'b0; cdr_in = 1'b1;
  endtask

  task automatic idle_clocks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic push_byte(input logic [7:0] d, input logic last);
    wr_valid = 1'b1; wr_data = d; wr_last = last;
    @(posedge clk); #2;
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic push_frame();
    for (int i = 0; i < fn; i++) push_byte(fb[i], (i == fn - 1));
  endtask

  task automatic build_expected();
    int ones;
    logic b;
    expn = 0;
    for (int i = 0; i < 8; i++) begin expv[expn] = ((8'h7E >> i) & 1) != 0; expn++; end
    ones = 0;
    for (int k = 0; k < fn; k++) begin
      for (int i = 0; i < 8; i++) begin
        b = fb[k][i];
        expv[expn] = b; expn++;
        ones = b ? ones + 1 : 0;
        if (ones == 5) begin expv[expn] = 1'b0; expn++; ones = 0; end
      end
    end
    for (int i = 0; i < 8; i++) begin expv[expn] = ((8'h7E >> i) & 1) != 0; expn++; end
  endtask

  task automatic check_stream(input string req);
    int start;
    int bad;
    start = -1; bad = -1;
    for (int i = 0; i < capn; i++) if (start < 0 && cap[i] == 1'b0) start = i;
    n_chk++;
    if (start < 0 || start + expn > capn) begin
      n_fail++;
      $display("FAIL %s frame: actual %0d captured bits expected frame of %0d bits", req, capn, expn);
    end else begin
      for (int i = 0; i < expn; i++) if (bad < 0 && cap[start + i] !== expv[i]) bad = i;
      for (int i = start + expn; i < capn; i++) if (bad < 0 && cap[i] !== 1'b1) bad = i - start;
      if (bad >= 0) begin
        n_fail++;
        $display("FAIL %s frame bit %0d: actual %0b expected %0b", req, bad,
                 cap[start + bad], (bad < expn) ? expv[bad] : 1'b1);
      end
    end
  endtask

  task automatic send_and_check(input string req);
    build_expected();
    capn = 0;
    push_frame();
    for (int i = 0; i < expn + 12; i++) line_step(1, 1, 1);
    check_stream(req);
  endtask

  task automatic t_reset();
    chk("R1", txd_oe, 1'b0, "txd_oe after reset");
    chk("R1", xdu_irq, 1'b0, "xdu_irq after reset");
    chk("R1", wr_full, 1'b0, "wr_full after reset");
  endtask

  task automatic t_idle();
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < 4; i++) begin
      line_step(1, 1, 1);
      if (txd_oe !== 1'b1 || txd !== 1'b1) ok = 1'b0;
    end
    chk("R3", ok, 1'b1, "idle fill ones driven");
    line_step(1, 0, 1);
    chk("R2", txd_oe, 1'b0, "oe after out-of-slot strobe");
  endtask

  task automatic t_frame();
    fb[0] = 8'hA5; fb[1] = 8'h3C; fn = 2;
    send_and_check("R5");
  endtask

  task automatic t_stuff();
    // last byte F8 ends in five ones: stuffed zero precedes closing flag
    fb[0] = 8'hFF; fb[1] = 8'h1F; fb[2] = 8'hF8; fn = 3;
    send_and_check("R6");
  endtask

  task automatic t_gate();
    logic ok;
    fb[0] = 8'h5A; fn = 1;
    build_expected();
    push_frame();
    capn = 0; ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      line_step(1, 1, 0);
      if (txd_oe !== 1'b0) ok = 1'b0;
    end
    chk("R4", ok, 1'b1, "oe held low while gate low");
    chk("R4", capn == 0, 1'b1, "no bits sent while gate low");
    for (int i = 0; i < expn + 12; i++) line_step(1, 1, 1);
    check_stream("R4");
  endtask

  task automatic t_slot();
    logic ok;
    fb[0] = 8'hC3; fb[1] = 8'h7E; fn = 2;
    build_expected();
    push_frame();
    capn = 0; ok = 1'b1;
    for (int i = 0; i < expn + 12; i++) begin
      line_step(1, 1, 1);
      line_step(1, 0, 0);
      if (txd_oe !== 1'b0) ok = 1'b0;
    end
    chk("R2", ok, 1'b1, "oe low after out-of-slot strobes");
    check_stream("R2");
  endtask

  task automatic t_abort();
    fb[0] = 8'h11; fb[1] = 8'h22; fb[2] = 8'h33; fn = 3;
    build_expected();
    push_frame();
    for (int i = 0; i < 20; i++) line_step(1, 1, 1);
    line_step(1, 1, 0);
    chk("R7", txd_oe, 1'b0, "oe after gate drop mid-frame");
    capn = 0;
    for (int i = 0; i < expn + 12; i++) line_step(1, 1, 1);
    check_stream("R8");
    chk("R8", xdu_irq, 1'b0, "no failure on replay");
  endtask

  task automatic t_fail();
    for (int i = 0; i < 8; i++) push_byte(8'h55, 1'b0);
    chk("R9", wr_full, 1'b1, "full with nothing sent");
    for (int i = 0; i < 24; i++) line_step(1, 1, 1);
    chk("R9", wr_full, 1'b0, "sent bytes evictable");
    push_byte(8'h55, 1'b0);
    push_byte(8'h55, 1'b1);
    chk("R9", wr_full, 1'b1, "full after evicting sent bytes");
    line_step(1, 1, 0);
    chk("R10", xdu_irq, 1'b1, "failure after abort with lost start");
    idle_clocks(12);
    chk("R10", wr_full, 1'b0, "failed frame discarded");
    fb[0] = 8'h81; fn = 1;
    send_and_check("R10");
  endtask

  task automatic t_clear();
    idle_clocks(3);
    chk("R11", xdu_irq, 1'b1, "interrupt sticky");
    xdu_clr = 1'b1;
    @(posedge clk); #2;
    xdu_clr = 1'b0;
    chk("R11", xdu_irq, 1'b0, "interrupt cleared");
  endtask

  task automatic t_underrun();
    push_byte(8'h0F, 1'b0);
    for (int i = 0; i < 17; i++) line_step(1, 1, 1);
    chk("R12", xdu_irq, 1'b1, "failure on underrun");
    push_byte(8'hF0, 1'b1);
    idle_clocks(4);
    xdu_clr = 1'b1;
    @(posedge clk); #2;
    xdu_clr = 1'b0;
    fb[0] = 8'h3C; fn = 1;
    send_and_check("R12");
    chk("R12", xdu_irq, 1'b0, "next frame clean");
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; slot_en = 1'b0; cdr_in = 1'b1;
    wr_valid = 1'b0; wr_data = 8'h00; wr_last = 1'b0; xdu_clr = 1'b0;
    capn = 0; expn = 0; fn = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_idle();
    t_frame();
    t_stuff();
    t_gate();
    t_slot();
    t_abort();
    t_fail();
    t_clear();
    t_underrun();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule